// File: doc/BRIEF.md
# Output DC Offset Window Monitor

This block watches four per-channel offset comparator outputs, one for each audio channel, over a measurement window whose length is set by the host. A channel is reported as having excess DC offset only if its comparator stays asserted for the whole window. The window has no fixed length. It opens when the offset enable bit goes high, or at a read event. It closes at the next read event. At that read the verdict is latched and becomes the value the read reports. Each read also opens the next window, so repeated reads keep the measurement running.

A short-circuit protection event on any channel during a window vetoes the whole result for that window. While the enable bit is low, no window runs and all flags read 0. In normal use the host sets the enable bit and waits some tens of milliseconds. It then reads again and again until the flags clear.

Top module: `ofs_window_mon`

## Requirements
- R1: After reset, `ofs_flag` is all zeros and `det_active` is 0.
- R2: In a cycle where `off_en` is 0, the outputs that follow are `ofs_flag` = 0 and `det_active` = 0. A `rd_start` pulse given during that cycle has no effect.
- R3: When `off_en` is 1 in a cycle, `det_active` is 1 in the next cycle. A rising edge of `off_en` opens a window.
- R4: A `rd_start` with `off_en` = 1 and a window open latches the verdict for each channel, visible one cycle later. Bit c of `ofs_flag` (c = 0..3, one bit per channel) is 1 only if `ofs_cmp[c]` was 1 on every cycle from the window's opening cycle through the read cycle, both included.
- R5: A single cycle with `ofs_cmp[c]` = 0 inside the window makes bit c of the next latched verdict 0.
- R6: If any bit of `prot_evt` is 1 on any cycle of the window, the read cycle included, every bit of the latched verdict is 0.
- R7: Each `rd_start` with `off_en` = 1 opens a new window at that same cycle. The read-cycle sample counts toward both the window that closes and the window that opens.
- R8: A `rd_start` on the same cycle as the rising edge of `off_en` closes a window of zero length and latches all zeros.
- R9: With `off_en` = 1 and no `rd_start`, `ofs_flag` holds its value.
- R10: `det_active` stays 1 for as long as `off_en` stays 1, across any number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_en | input | 1 | Offset detection enable level |
| rd_start | input | 1 | One-cycle pulse marking a read event |
| ofs_cmp | input | NCH | Per-channel offset comparator outputs |
| prot_evt | input | NCH | Per-channel short-circuit protection activity |
| ofs_flag | output | NCH | Latched per-channel excess-offset verdict |
| det_active | output | 1 | High while offset detection is running |

## Verification
Every result is registered once, so each is due exactly one cycle after the stimulus that causes it:
- a verdict appears on the cycle after its read pulse;
- `det_active` follows `off_en` one cycle later;
- a low enable clears the flags on the next cycle.

The bench drives inputs on the falling edge. After each rising edge, it advances its own window model with the inputs the design just sampled. It compares the outputs on the following falling edge, so every comparison lands on the cycle where the result is due.

// File: rtl/ofs_window_mon.sv
module ofs_window_mon #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           off_en,
  input  logic           rd_start,
  input  logic [NCH-1:0] ofs_cmp,
  input  logic [NCH-1:0] prot_evt,
  output logic [NCH-1:0] ofs_flag,
  output logic           det_active
);

  logic           en_q, win_q, veto_q;
  logic [NCH-1:0] stay_q, flag_q;
  logic           any_prot, opening;

  assign any_prot   = |prot_evt;
  assign opening    = (off_en & ~en_q) | rd_start;
  assign ofs_flag   = flag_q;
  assign det_active = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      win_q  <= 1'b0;
      veto_q <= 1'b0;
      stay_q <= '0;
      flag_q <= '0;
    end else begin
      en_q <= off_en;
      if (!off_en) begin
        win_q  <= 1'b0;
        veto_q <= 1'b0;
        stay_q <= '0;
        flag_q <= '0;
      end else begin
        if (rd_start)
          flag_q <= win_q ? (stay_q & ofs_cmp & {NCH{~(veto_q | any_prot)}}) : '0;
        if (opening) begin
          win_q  <= 1'b1;
          stay_q <= ofs_cmp;
          veto_q <= any_prot;
        end else if (win_q) begin
          stay_q <= stay_q & ofs_cmp;
          veto_q <= veto_q | any_prot;
        end
      end
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !off_en |=> (ofs_flag == '0) && !det_active); // R2
  AST_EN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    off_en |=> det_active); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && !rd_start) |=> $stable(ofs_flag)); // R9
  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && rd_start) |=> ((ofs_flag & ~$past(ofs_cmp)) == '0)); // R5
  AST_PROT_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && rd_start && (prot_evt != '0)) |=> (ofs_flag == '0)); // R6
  AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && !en_q && rd_start) |=> (ofs_flag == '0)); // R8

endmodule

// File: tb/ofs_window_mon_tb_top.sv
module ofs_window_mon_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic off_en = 1'b0, rd_start = 1'b0;
  logic [NCH-1:0] ofs_cmp = '0, prot_evt = '0;
  logic [NCH-1:0] ofs_flag;
  logic det_active;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_en_prev = 0, m_open = 0, m_veto = 0, m_act = 0;
  logic [NCH-1:0] m_high = '0, m_flag = '0;

  always #10 clk = ~clk;

  ofs_window_mon #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .off_en(off_en), .rd_start(rd_start),
    .ofs_cmp(ofs_cmp), .prot_evt(prot_evt),
    .ofs_flag(ofs_flag), .det_active(det_active)
  );

  task automatic check(input string req, input logic [NCH-1:0] f, input bit a);
    n_chk++;
    if (ofs_flag !== f || det_active !== a) begin
      n_bad++;
      $display("FAIL %s: flag=%b act=%b expected flag=%b act=%b", req, ofs_flag, det_active, f, a);
    end
  endtask

  function automatic logic [NCH-1:0] verdict(input bit open, input bit veto,
      input logic [NCH-1:0] high, input logic [NCH-1:0] cmp, input logic [NCH-1:0] prot);
    if (!open || veto || prot != '0) return '0;
    return high & cmp;
  endfunction

  task automatic step(input bit en, input bit rd, input logic [NCH-1:0] cmp,
                      input logic [NCH-1:0] prot, input string req);
    bit rise;
    off_en = en; rd_start = rd; ofs_cmp = cmp; prot_evt = prot;
    @(posedge clk);
    @(negedge clk);
    rise = en && !m_en_prev;
    if (!en) begin
      m_open = 0; m_veto = 0; m_high = '0; m_flag = '0; m_act = 0;   // R2
    end else begin
      if (rd) m_flag = verdict(m_open, m_veto, m_high, cmp, prot);    // R4 R8
      if (rise || rd) begin
        m_open = 1; m_high = cmp; m_veto = (prot != '0);              // R3 R7
      end else if (m_open) begin
        m_high = m_high & cmp; m_veto = m_veto | (prot != '0);        // R5 R6
      end
      m_act = 1;                                                      // R10
    end
    m_en_prev = en;
    check(req, m_flag, m_act);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 0);

    // R2: read while disabled does nothing
    step(0, 1, 4'hF, 4'h0, "R2");
    // R8: read at the enable edge gives zero-length window
    step(1, 1, 4'hF, 4'h0, "R8");
    // R3/R4: all channels high for a window
    for (int i = 0; i < 8; i++) step(1, 0, 4'hF, 4'h0, "R3");
    step(1, 1, 4'hF, 4'h0, "R4");
    // R7/R9: new window already open, hold until next read
    for (int i = 0; i < 5; i++) step(1, 0, 4'hF, 4'h0, "R9");
    step(1, 1, 4'hF, 4'h0, "R7");
    // R5: channel 2 dips once
    step(1, 0, 4'hF, 4'h0, "R5");
    step(1, 0, 4'hB, 4'h0, "R5");
    step(1, 0, 4'hF, 4'h0, "R5");
    step(1, 1, 4'hF, 4'h0, "R5");
    // R6: protection mid window
    step(1, 0, 4'hF, 4'h0, "R6");
    step(1, 0, 4'hF, 4'h2, "R6");
    step(1, 1, 4'hF, 4'h0, "R6");
    step(1, 0, 4'hF, 4'h0, "R6");
    step(1, 1, 4'hF, 4'h0, "R10");
    // R2: disable clears
    step(0, 0, 4'hF, 4'h0, "R2");
    step(0, 1, 4'hF, 4'h0, "R2");

    // random phase
    void'($urandom(32'd1234));
    begin
      bit en = 1;
      for (int i = 0; i < 3000; i++) begin
        logic [NCH-1:0] c, p;
        bit rd;
        if ($urandom_range(0, 299) == 0) en = !en;
        rd = ($urandom_range(0, 14) == 0);
        for (int k = 0; k < NCH; k++) c[k] = ($urandom_range(0, 39) != 0);
        p = ($urandom_range(0, 149) == 0) ? 4'(1 << $urandom_range(0, 3)) : '0;
        step(en, rd, c, p, rd ? "R4" : (en ? "R9" : "R2"));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule